// File: doc/BRIEF.md
# Burst Write Collector with Byte Lanes

This block is the write half of a memory with separate read and write ports. A write request is sampled on a rising clock edge, and the line address is captured with it. The block then gathers four 18-bit data words over the next two cycles. Each cycle delivers two words: one on the rising-edge lane and one on the falling-edge lane. Every word carries its own two-bit byte-lane enable. One cycle after the last word arrives, the assembled 72-bit line is committed to the internal array in a single masked update. Lanes whose enable was low keep their old contents.

A burst takes two cycles on the data inputs, so a request in the cycle right after an accepted one is dropped. Requests can therefore be accepted on alternate cycles, which keeps the data inputs busy without a gap. While a burst is still being collected, or is waiting to be committed, its address, data and lane enables are shown on forwarding outputs, so that a neighbouring read path can return the newest data. A registered read port lets the array be read back.

Top module: `burst_write_collector`

## Requirements
- R1: A request (`wr_req` high) is accepted at a rising edge unless a request was accepted at the previous edge. After the accepting edge, `fwd_open_vld` is high and `fwd_open_addr` holds the captured `wr_addr`.
- R2: A request at the edge right after an accepted request is ignored. It changes neither the array nor the forwarding outputs, and `fwd_line_vld` gives no pulse for it.
- R3: Words 0 and 1 (`wr_d_rise`, `wr_d_fall`) are captured at the first edge after acceptance, and words 2 and 3 at the second edge. Before the first pair arrives, `fwd_open_be` reads zero. After it arrives, `fwd_open_data` is {word1, word0} and `fwd_open_be` is {be1, be0}.
- R4: In the committed line, word k occupies bits [18k+17:18k].
- R5: Bit 0 of a word's enable covers bits 8:0 of that word and bit 1 covers bits 17:9. Line lane j is bits [9j+8:9j] and uses enable bit j of `fwd_line_be`. The commit writes only the enabled lanes; the other lanes keep their stored value.
- R6: `fwd_line_vld` is high for exactly the one cycle after the edge that captures words 2 and 3. The array is written at the edge that ends that cycle.
- R7: With requests on alternate cycles, every request is accepted and committed. A new request may be accepted at the same edge that captures the previous burst's last words.
- R8: After a reset edge (`rst` high, synchronous), `fwd_open_vld` and `fwd_line_vld` are low.
- R9: `rd_data` returns the line at `rd_addr` one edge after the address is presented. If a commit writes the same line at that edge, `rd_data` returns the old contents.
- R10: While no burst is open, the data and enable inputs have no effect on the array or the forwarding outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_req | input | 1 | Write request, sampled at the rising edge |
| wr_addr | input | ADDR_W | Line address captured with an accepted request |
| wr_d_rise | input | 18 | Even-numbered data word of the current pair |
| wr_d_fall | input | 18 | Odd-numbered data word of the current pair |
| wr_be_rise | input | 2 | Byte-lane enables for `wr_d_rise` |
| wr_be_fall | input | 2 | Byte-lane enables for `wr_d_fall` |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | 72 | Registered array read data |
| fwd_open_vld | output | 1 | A burst is being collected |
| fwd_open_addr | output | ADDR_W | Address of the open burst |
| fwd_open_data | output | 36 | Words 1 and 0 of the open burst |
| fwd_open_be | output | 4 | Lane enables for words 1 and 0 |
| fwd_line_vld | output | 1 | A complete line is committed at the next edge |
| fwd_line_addr | output | ADDR_W | Address of the line to be committed |
| fwd_line_data | output | 72 | Assembled line |
| fwd_line_be | output | 8 | Lane enables of the assembled line |

## Verification
Under back-to-back traffic, two events share an edge: the last word pair of one burst is captured while the next request is accepted. At the following edge, the first line is committed while the second burst's first pair is captured. The bench provokes this by requesting on alternate cycles and by holding the request high continuously. In the second case every other request must be dropped. A reference model replays the same per-cycle script and decides acceptance on its own. Each cycle it predicts every forwarding output, and afterwards it compares the whole array through the read port. A directed case also reads a line at the same edge it is committed, to confirm that the old contents are returned.

// File: rtl/bwc_pkg.sv
package bwc_pkg;

  // Number of data words gathered per write burst (two per cycle).
  localparam int BURST_WORDS = 4;
  localparam int WORDS_PER_CYCLE = 2;

  // Collection phase of the write sequencer.
  typedef enum logic [1:0] {
    COL_IDLE   = 2'd0,
    COL_FIRST  = 2'd1,
    COL_SECOND = 2'd2
  } col_phase_t;

endpackage

// File: rtl/bwc_req_seq.sv
module bwc_req_seq
  import bwc_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              accept_o,
  output logic              take_first_o,
  output logic              take_second_o,
  output logic              busy_o,
  output logic [ADDR_W-1:0] addr_q_o
);

  col_phase_t phase_q, phase_d;

  // A request is dropped only while the first word pair of the previous one is pending.
  assign accept_o = req_i && (phase_q != COL_FIRST);

  always_comb begin
    case (phase_q)
      COL_FIRST: phase_d = COL_SECOND;
      default:   phase_d = accept_o ? COL_FIRST : COL_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= COL_IDLE;
      addr_q_o <= '0;
    end else begin
      phase_q <= phase_d;
      if (accept_o) addr_q_o <= addr_i;
    end
  end

  assign take_first_o  = (phase_q == COL_FIRST);
  assign take_second_o = (phase_q == COL_SECOND);
  assign busy_o        = (phase_q != COL_IDLE);

  AST_NO_B2B_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    accept_o |=> !accept_o); // R2
  AST_ACCEPT_OPENS: assert property (@(posedge clk) disable iff (rst)
    accept_o |=> (phase_q == COL_FIRST) && (addr_q_o == $past(addr_i))); // R1
  AST_FIRST_THEN_SECOND: assert property (@(posedge clk) disable iff (rst)
    (phase_q == COL_FIRST) |=> (phase_q == COL_SECOND)); // R3

endmodule

// File: rtl/bwc_gather.sv
module bwc_gather
  import bwc_pkg::*;
#(
  parameter int WORD_W = 18,
  parameter int LANE_W = 9,
  parameter int ADDR_W = 6,
  localparam int LPW = WORD_W / LANE_W,
  localparam int PAIR_W = WORDS_PER_CYCLE * WORD_W,
  localparam int PAIR_L = WORDS_PER_CYCLE * LPW,
  localparam int LINE_W = BURST_WORDS * WORD_W,
  localparam int LINE_L = BURST_WORDS * LPW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept_i,
  input  logic              take_first_i,
  input  logic              take_second_i,
  input  logic [ADDR_W-1:0] addr_q_i,
  input  logic [WORD_W-1:0] d_rise_i,
  input  logic [WORD_W-1:0] d_fall_i,
  input  logic [LPW-1:0]    be_rise_i,
  input  logic [LPW-1:0]    be_fall_i,
  output logic [PAIR_W-1:0] open_data_o,
  output logic [PAIR_L-1:0] open_be_o,
  output logic              line_vld_o,
  output logic [ADDR_W-1:0] line_addr_o,
  output logic [LINE_W-1:0] line_data_o,
  output logic [LINE_L-1:0] line_be_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      open_data_o <= '0;
      open_be_o   <= '0;
      line_vld_o  <= 1'b0;
      line_addr_o <= '0;
      line_data_o <= '0;
      line_be_o   <= '0;
    end else begin
      line_vld_o <= take_second_i;
      if (take_first_i) begin
        open_data_o <= {d_fall_i, d_rise_i};
        open_be_o   <= {be_fall_i, be_rise_i};
      end else if (accept_i) begin
        open_be_o <= '0;
      end
      if (take_second_i) begin
        line_addr_o <= addr_q_i;
        line_data_o <= {d_fall_i, d_rise_i, open_data_o};
        line_be_o   <= {be_fall_i, be_rise_i, open_be_o};
      end
    end
  end

  AST_LINE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    line_vld_o |=> !line_vld_o); // R6
  AST_FIRST_MASK_EMPTY: assert property (@(posedge clk) disable iff (rst)
    take_first_i |-> (open_be_o == '0)); // R3

endmodule

// File: rtl/bwc_lane_array.sv
module bwc_lane_array #(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 8,
  localparam int DEPTH  = 1 << ADDR_W,
  localparam int LINE_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [LINE_W-1:0] wdata_i,
  input  logic [LANES-1:0]  wbe_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [LINE_W-1:0] rdata_o
);

  // One narrow memory per byte lane so each maps onto a RAM column with its own enable.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (we_i && wbe_i[g]) mem[waddr_i] <= wdata_i[g*LANE_W +: LANE_W];
      rd_q <= mem[raddr_i];
    end

    assign rdata_o[g*LANE_W +: LANE_W] = rd_q;
  end

endmodule

// File: rtl/burst_write_collector.sv
module burst_write_collector
  import bwc_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 18,
  parameter int LANE_W = 9,
  localparam int LPW = WORD_W / LANE_W,
  localparam int PAIR_W = WORDS_PER_CYCLE * WORD_W,
  localparam int PAIR_L = WORDS_PER_CYCLE * LPW,
  localparam int LINE_W = BURST_WORDS * WORD_W,
  localparam int LINE_L = BURST_WORDS * LPW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_d_rise,
  input  logic [WORD_W-1:0] wr_d_fall,
  input  logic [LPW-1:0]    wr_be_rise,
  input  logic [LPW-1:0]    wr_be_fall,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [LINE_W-1:0] rd_data,
  output logic              fwd_open_vld,
  output logic [ADDR_W-1:0] fwd_open_addr,
  output logic [PAIR_W-1:0] fwd_open_data,
  output logic [PAIR_L-1:0] fwd_open_be,
  output logic              fwd_line_vld,
  output logic [ADDR_W-1:0] fwd_line_addr,
  output logic [LINE_W-1:0] fwd_line_data,
  output logic [LINE_L-1:0] fwd_line_be
);

  logic accept, take_first, take_second;

  bwc_req_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .req_i        (wr_req),
    .addr_i       (wr_addr),
    .accept_o     (accept),
    .take_first_o (take_first),
    .take_second_o(take_second),
    .busy_o       (fwd_open_vld),
    .addr_q_o     (fwd_open_addr)
  );

  bwc_gather #(.WORD_W(WORD_W), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_gather (
    .clk          (clk),
    .rst          (rst),
    .accept_i     (accept),
    .take_first_i (take_first),
    .take_second_i(take_second),
    .addr_q_i     (fwd_open_addr),
    .d_rise_i     (wr_d_rise),
    .d_fall_i     (wr_d_fall),
    .be_rise_i    (wr_be_rise),
    .be_fall_i    (wr_be_fall),
    .open_data_o  (fwd_open_data),
    .open_be_o    (fwd_open_be),
    .line_vld_o   (fwd_line_vld),
    .line_addr_o  (fwd_line_addr),
    .line_data_o  (fwd_line_data),
    .line_be_o    (fwd_line_be)
  );

  bwc_lane_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LINE_L)) u_array (
    .clk    (clk),
    .we_i   (fwd_line_vld),
    .waddr_i(fwd_line_addr),
    .wdata_i(fwd_line_data),
    .wbe_i  (fwd_line_be),
    .raddr_i(rd_addr),
    .rdata_o(rd_data)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!fwd_open_vld && !fwd_line_vld)); // R8

endmodule

// File: tb/test_burst_write_collector.sv
`timescale 1ns/1ps
module test_burst_write_collector;

  localparam int AW = 6;
  localparam int NL = 1 << AW;
  localparam int SL = 256;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_req = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [17:0]   wr_d_rise = '0, wr_d_fall = '0;
  logic [1:0]    wr_be_rise = '0, wr_be_fall = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [71:0]   rd_data;
  logic          fwd_open_vld;
  logic [AW-1:0] fwd_open_addr;
  logic [35:0]   fwd_open_data;
  logic [3:0]    fwd_open_be;
  logic          fwd_line_vld;
  logic [AW-1:0] fwd_line_addr;
  logic [71:0]   fwd_line_data;
  logic [7:0]    fwd_line_be;

  burst_write_collector #(.ADDR_W(AW)) i_burst_write_collector (
    .clk(clk), .rst(rst), .wr_req(wr_req), .wr_addr(wr_addr),
    .wr_d_rise(wr_d_rise), .wr_d_fall(wr_d_fall),
    .wr_be_rise(wr_be_rise), .wr_be_fall(wr_be_fall),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .fwd_open_vld(fwd_open_vld), .fwd_open_addr(fwd_open_addr),
    .fwd_open_data(fwd_open_data), .fwd_open_be(fwd_open_be),
    .fwd_line_vld(fwd_line_vld), .fwd_line_addr(fwd_line_addr),
    .fwd_line_data(fwd_line_data), .fwd_line_be(fwd_line_be)
  );

  always #2.5 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;

  // Per-cycle stimulus script and reference state
  bit          s_req [SL];
  bit          s_acc [SL];
  logic [AW-1:0] s_addr [SL];
  logic [17:0] s_dr [SL], s_df [SL];
  logic [1:0]  s_br [SL], s_bf [SL];
  logic [71:0] ref_mem [NL];

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic chk(input string tag, input logic [71:0] act, input logic [71:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [71:0] merge(input logic [71:0] old, input logic [71:0] nw,
                                        input logic [7:0] be);
    logic [71:0] r = old;
    for (int j = 0; j < 8; j++) if (be[j]) r[9*j +: 9] = nw[9*j +: 9];
    return r;
  endfunction

  task automatic clear_script();
    for (int i = 0; i < SL; i++) begin
      s_req[i] = 0; s_acc[i] = 0; s_addr[i] = '0;
      s_dr[i] = '0; s_df[i] = '0; s_br[i] = '0; s_bf[i] = '0;
    end
  endtask

  task automatic drive(input int i);
    wr_req = s_req[i]; wr_addr = s_addr[i];
    wr_d_rise = s_dr[i]; wr_d_fall = s_df[i];
    wr_be_rise = s_br[i]; wr_be_fall = s_bf[i];
  endtask

  // Expected outputs after edge e, derived from the script alone
  task automatic check_edge(input int e, input string ctx);
    bit exp_open = s_acc[e] || (e > 0 && s_acc[e-1]);
    bit exp_line = (e >= 2) && s_acc[e-2];
    chk({ctx, " R1 open_vld"}, fwd_open_vld, exp_open);
    if (s_acc[e]) begin
      chk({ctx, " R1 open_addr"}, fwd_open_addr, s_addr[e]);
      chk({ctx, " R3 open_be before pair"}, fwd_open_be, 4'b0);
    end else if (e > 0 && s_acc[e-1]) begin
      chk({ctx, " R1 open_addr"}, fwd_open_addr, s_addr[e-1]);
      chk({ctx, " R3 open_data"}, fwd_open_data, {s_df[e], s_dr[e]});
      chk({ctx, " R3 open_be"}, fwd_open_be, {s_bf[e], s_br[e]});
    end
    chk({ctx, " R6 line_vld"}, fwd_line_vld, exp_line);
    if (exp_line) begin
      chk({ctx, " R6 line_addr"}, fwd_line_addr, s_addr[e-2]);
      chk({ctx, " R4 line_data"}, fwd_line_data, {s_df[e], s_dr[e], s_df[e-1], s_dr[e-1]});
      chk({ctx, " R5 line_be"}, fwd_line_be, {s_bf[e], s_br[e], s_bf[e-1], s_br[e-1]});
    end
  endtask

  task automatic play(input int len, input string ctx);
    for (int i = 0; i < len + 4; i++)
      s_acc[i] = s_req[i] && !(i > 0 && s_acc[i-1]);
    for (int i = 0; i <= len + 3; i++) begin
      @(negedge clk);
      if (i > 0) check_edge(i - 1, ctx);
      drive(i);
    end
    @(negedge clk);
    check_edge(len + 3, ctx);
    for (int c = 0; c < len; c++)
      if (s_acc[c])
        ref_mem[s_addr[c]] = merge(ref_mem[s_addr[c]],
          {s_df[c+2], s_dr[c+2], s_df[c+1], s_dr[c+1]},
          {s_bf[c+2], s_br[c+2], s_bf[c+1], s_br[c+1]});
  endtask

  task automatic read_line(input logic [AW-1:0] a, output logic [71:0] d);
    @(negedge clk); rd_addr = a;
    @(negedge clk); d = rd_data;
  endtask

  task automatic verify_all(input string ctx);
    logic [71:0] d;
    for (int a = 0; a < NL; a++) begin
      read_line(AW'(a), d);
      chk({ctx, " R5 array line"}, d, ref_mem[a]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [71:0] old_v, new_v, d;
    void'($urandom(32'h5EED_0F2A));

    // R8: quiet outputs after reset, even with a request held high
    wr_req = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 open_vld after reset", fwd_open_vld, 1'b0);
    chk("R8 line_vld after reset", fwd_line_vld, 1'b0);
    wr_req = 1'b0;
    rst = 1'b0;

    // R7: fill every line with requests on alternate cycles
    clear_script();
    for (int k = 0; k < NL; k++) begin
      s_req[2*k] = 1; s_addr[2*k] = AW'(k);
      s_dr[2*k+1] = 18'($urandom); s_df[2*k+1] = 18'($urandom);
      s_dr[2*k+2] = 18'($urandom); s_df[2*k+2] = 18'($urandom);
      s_br[2*k+1] = 2'b11; s_bf[2*k+1] = 2'b11;
      s_br[2*k+2] = 2'b11; s_bf[2*k+2] = 2'b11;
    end
    for (int a = 0; a < NL; a++) ref_mem[a] = 'x;
    play(2 * NL, "R7 alternate");
    verify_all("R7");

    // R2: request held high every cycle, every second one must drop
    clear_script();
    for (int i = 0; i < 24; i++) begin
      s_req[i] = 1; s_addr[i] = AW'($urandom);
      s_dr[i] = 18'($urandom); s_df[i] = 18'($urandom);
      s_br[i] = 2'($urandom); s_bf[i] = 2'($urandom);
    end
    for (int i = 24; i < 27; i++) begin
      s_dr[i] = 18'($urandom); s_df[i] = 18'($urandom);
      s_br[i] = 2'($urandom); s_bf[i] = 2'($urandom);
    end
    play(24, "R2 continuous");
    verify_all("R2");

    // R5: directed lane masks on one line
    clear_script();
    s_req[0] = 1; s_addr[0] = AW'(5);
    s_dr[1] = 18'h2A5A5; s_br[1] = 2'b01;
    s_df[1] = 18'h1C3C3; s_bf[1] = 2'b10;
    s_dr[2] = 18'h3FFFF; s_br[2] = 2'b00;
    s_df[2] = 18'h05A5A; s_bf[2] = 2'b11;
    old_v = ref_mem[5];
    new_v = old_v;
    new_v[8:0]   = s_dr[1][8:0];
    new_v[35:27] = s_df[1][17:9];
    new_v[71:54] = s_df[2];
    play(1, "R5 directed");
    read_line(AW'(5), d);
    chk("R5 directed lanes", d, new_v);

    // Random traffic with random masks and gaps
    clear_script();
    for (int i = 0; i < 160; i++) begin
      s_req[i] = ($urandom % 2) == 0; s_addr[i] = AW'($urandom);
      s_dr[i] = 18'($urandom); s_df[i] = 18'($urandom);
      s_br[i] = 2'($urandom); s_bf[i] = 2'($urandom);
    end
    play(160, "R4 random");
    verify_all("R4 random");

    // R10: busy data inputs with no request leave everything untouched
    clear_script();
    for (int i = 0; i < 23; i++) begin
      s_addr[i] = AW'($urandom);
      s_dr[i] = 18'($urandom); s_df[i] = 18'($urandom);
      s_br[i] = 2'b11; s_bf[i] = 2'b11;
    end
    play(20, "R10 deselected");
    verify_all("R10");

    // R9: read of a line at the very edge it is committed returns old data
    old_v = ref_mem[9];
    @(negedge clk);
    wr_req = 1; wr_addr = AW'(9);
    @(negedge clk);
    wr_req = 0; wr_d_rise = 18'h11111; wr_d_fall = 18'h22222;
    wr_be_rise = 2'b11; wr_be_fall = 2'b11;
    @(negedge clk);
    wr_d_rise = 18'h33333; wr_d_fall = 18'h04444;
    @(negedge clk);
    wr_d_rise = '0; wr_d_fall = '0; wr_be_rise = '0; wr_be_fall = '0;
    rd_addr = AW'(9);
    @(negedge clk);
    chk("R9 read at commit edge", rd_data, old_v);
    @(negedge clk);
    new_v = {18'h04444, 18'h33333, 18'h22222, 18'h11111};
    chk("R9 read after commit", rd_data, new_v);
    ref_mem[9] = new_v;
    verify_all("R9 final");

    summary();
    $finish;
  end

endmodule